// File: doc/BRIEF.md
# APB Peripheral Control Register Bank

This block is the register file at the front of a serial peripheral, reached over an APB slave port. Software writes a control word at offset 0x000, whose bit 0 switches the peripheral on through the `periph_en` output. It reads back a status word at offset 0x004 and uses a small set of general scratch words that start at offset 0x008. Each access is held off by a fixed number of wait states that a parameter sets. The slave keeps `pready` low for that many access cycles and then raises it for exactly one cycle, and that cycle completes the transfer.

A three-state access machine drives `pready`:
- **IDLE**: no transfer is under way. A setup cycle (`psel` high, `penable` low) moves it to **WAIT**, or straight to **READY** when the wait count is zero.
- **WAIT**: counts access cycles. When the last wait cycle has been counted it moves to **READY**. If `psel` drops, the transfer is aborted and the machine returns to **IDLE**.
- **READY**: drives `pready` high. Writes take effect and read data is shown on `prdata` in this cycle. The machine always returns to **IDLE** after it.

There are two resets. `preset_n` is the system reset: asynchronous and active low. `slv_rst` is a synchronous, active-high reset local to the peripheral. Either one clears every stored register and returns the machine to IDLE.

Top module: `apb_ctrl_regbank`

## Requirements
- R1: While `preset_n` is low, and without waiting for a clock edge, `pready`, `prdata` and `periph_en` are 0 and all stored registers read 0 afterwards.
- R2: `slv_rst` high at a rising edge clears the control word and all scratch words to 0.
- R3: Each transfer keeps `pready` low for exactly WAIT_CYCLES access cycles (default 2), then holds it high for one cycle only.
- R4: A write changes a register only at the edge that ends the access cycle in which `pready` is high. During wait cycles the old value still holds.
- R5: The control word at 0x000 is 32 bits, fully writable, and reads back the value last written.
- R6: `periph_en` equals bit 0 of the control word.
- R7: The word at 0x004 is read-only. Bit 0 is the enable bit. Bit 1 is the busy flag, which is 1 when the current transfer was stretched by at least one wait cycle (always 1 when WAIT_CYCLES > 0). All other bits are 0. Writes to 0x004 change nothing.
- R8: NUM_SCRATCH writable 32-bit words (default 2) sit at 0x008 + 4*k and read back what was written.
- R9: Every other address, including ones not aligned to 4 bytes, reads 0, and writes to it change no register.
- R10: `prdata` is 0 in every cycle in which `pready` is low.
- R11: If `psel` falls before `pready` has been high, the transfer is dropped and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| preset_n | input | 1 | Asynchronous active-low system reset |
| slv_rst | input | 1 | Synchronous active-high peripheral reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (10) | Byte address |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while pready is high |
| pready | output | 1 | Transfer completes in this cycle |
| periph_en | output | 1 | Peripheral enable, control bit 0 |

## Verification
The bench sends four kinds of transfer:
- Full-width writes and reads of the control and scratch words, with values such as 0xA5A50001 and 0xDEADBEEF. These separate correct storage from bit loss.
- Writes to the status word and to unmapped, misaligned and out-of-range addresses. These separate read-only and ignored locations from storing ones.
- A transfer dropped after its first access cycle. This separates abort from a late commit.
- A control write from 1 to 0 whose wait cycles are watched. This separates commit at completion from an early update.

Both resets are applied in the middle of a sequence, so the clear to zero is seen at the ports and in later reads.

// File: rtl/apb_rb_pkg.sv
package apb_rb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } apb_state_e;

    localparam int unsigned CTRL_OFS = 32'h000;
    localparam int unsigned STAT_OFS = 32'h004;
    localparam int unsigned SCR_BASE = 32'h008;
    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/apb_rb_fsm.sv
module apb_rb_fsm
    import apb_rb_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic preset_n,
    input  logic slv_rst,
    input  logic psel,
    input  logic penable,
    output logic pready,
    output logic busy,
    output logic xfer_done
);

    localparam int unsigned CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT =
        CNT_W'((WAIT_CYCLES > 0) ? WAIT_CYCLES - 1 : 0);

    apb_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic busy_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (psel && !penable)
                    state_d = (WAIT_CYCLES == 0) ? ST_READY : ST_WAIT;
            end
            ST_WAIT: begin
                if (!psel)
                    state_d = ST_IDLE;
                else if (penable && cnt_q == LAST_CNT)
                    state_d = ST_READY;
            end
            ST_READY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and wait counter
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (slv_rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && psel && penable)
                cnt_q <= cnt_q + 1'b1;
            else
                cnt_q <= '0;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)
            busy_q <= 1'b0;
        else if (slv_rst)
            busy_q <= 1'b0;
        else
            busy_q <= (state_d == ST_WAIT) || (state_d == ST_READY && busy_q);
    end

    always_comb begin
        pready    = (state_q == ST_READY);
        xfer_done = pready && psel && penable;
        busy      = busy_q;
    end

    // independent access-cycle counter for the wait-length check
    logic [31:0] chk_acc;
    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)
            chk_acc <= '0;
        else if (slv_rst || xfer_done || !psel)
            chk_acc <= '0;
        else if (psel && penable)
            chk_acc <= chk_acc + 1;
    end

    // R3
    wait_len_chk: assert property (@(posedge clk) disable iff (!preset_n || slv_rst)
        (pready && psel && penable) |-> (chk_acc == WAIT_CYCLES));

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!preset_n)
        pready |=> !pready);

    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!preset_n)
        (!psel && !slv_rst) |=> !pready);

endmodule

// File: rtl/apb_rb_decode.sv
module apb_rb_decode
    import apb_rb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned NUM_SCRATCH = 2
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic                   sel_ctrl,
    output logic                   sel_stat,
    output logic [NUM_SCRATCH-1:0] sel_scr
);

    assign sel_ctrl = (addr == ADDR_W'(CTRL_OFS));
    assign sel_stat = (addr == ADDR_W'(STAT_OFS));

    for (genvar k = 0; k < NUM_SCRATCH; k++) begin : g_scr_dec
        assign sel_scr[k] = (addr == ADDR_W'(SCR_BASE + WORD_BYTES * k));
    end

endmodule

// File: rtl/apb_rb_regfile.sv
module apb_rb_regfile #(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned NUM_SCRATCH = 2
) (
    input  logic                   clk,
    input  logic                   preset_n,
    input  logic                   slv_rst,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic                   sel_ctrl,
    input  logic                   sel_stat,
    input  logic [NUM_SCRATCH-1:0] sel_scr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic                   busy,
    output logic [DATA_W-1:0]      rdata,
    output logic [DATA_W-1:0]      ctrl_q
);

    logic [DATA_W-1:0] scr_q [NUM_SCRATCH];
    logic [DATA_W-1:0] stat_word;

    always_ff @(posedge clk or negedge preset_n) begin
        if (!preset_n)
            ctrl_q <= '0;
        else if (slv_rst)
            ctrl_q <= '0;
        else if (wr_en && sel_ctrl)
            ctrl_q <= wdata;
    end

    for (genvar k = 0; k < NUM_SCRATCH; k++) begin : g_scr
        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)
                scr_q[k] <= '0;
            else if (slv_rst)
                scr_q[k] <= '0;
            else if (wr_en && sel_scr[k])
                scr_q[k] <= wdata;
        end

        // R2
        scr_rst_chk: assert property (@(posedge clk) disable iff (!preset_n)
            slv_rst |=> (scr_q[k] == '0));

        // R11
        scr_hold_chk: assert property (@(posedge clk) disable iff (!preset_n)
            (!(wr_en && sel_scr[k]) && !slv_rst) |=> $stable(scr_q[k]));
    end

    assign stat_word = {{(DATA_W-2){1'b0}}, busy, ctrl_q[0]};

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_ctrl) rdata = ctrl_q;
            if (sel_stat) rdata = stat_word;
            for (int k = 0; k < NUM_SCRATCH; k++)
                if (sel_scr[k]) rdata = scr_q[k];
        end
    end

    // R4
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!preset_n)
        (wr_en && sel_ctrl && !slv_rst) |=> (ctrl_q == $past(wdata)));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!preset_n)
        (!(wr_en && sel_ctrl) && !slv_rst) |=> $stable(ctrl_q));

    // R2
    ctrl_rst_chk: assert property (@(posedge clk) disable iff (!preset_n)
        slv_rst |=> (ctrl_q == '0));

endmodule

// File: rtl/apb_ctrl_regbank.sv
module apb_ctrl_regbank
    import apb_rb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 10,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned WAIT_CYCLES = 2,
    parameter int unsigned NUM_SCRATCH = 2
) (
    input  logic              pclk,
    input  logic              preset_n,
    input  logic              slv_rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              periph_en
);

    logic                   busy;
    logic                   xfer_done;
    logic                   wr_en;
    logic                   rd_en;
    logic                   sel_ctrl;
    logic                   sel_stat;
    logic [NUM_SCRATCH-1:0] sel_scr;
    logic [DATA_W-1:0]      ctrl_q;

    apb_rb_fsm #(
        .WAIT_CYCLES(WAIT_CYCLES)
    ) u_fsm (
        .clk      (pclk),
        .preset_n (preset_n),
        .slv_rst  (slv_rst),
        .psel     (psel),
        .penable  (penable),
        .pready   (pready),
        .busy     (busy),
        .xfer_done(xfer_done)
    );

    apb_rb_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_SCRATCH(NUM_SCRATCH)
    ) u_dec (
        .addr    (paddr),
        .sel_ctrl(sel_ctrl),
        .sel_stat(sel_stat),
        .sel_scr (sel_scr)
    );

    assign wr_en = xfer_done && pwrite;
    assign rd_en = xfer_done && !pwrite;

    apb_rb_regfile #(
        .DATA_W     (DATA_W),
        .NUM_SCRATCH(NUM_SCRATCH)
    ) u_regs (
        .clk     (pclk),
        .preset_n(preset_n),
        .slv_rst (slv_rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .sel_ctrl(sel_ctrl),
        .sel_stat(sel_stat),
        .sel_scr (sel_scr),
        .wdata   (pwdata),
        .busy    (busy),
        .rdata   (prdata),
        .ctrl_q  (ctrl_q)
    );

    assign periph_en = ctrl_q[0];

    // R10
    rdata_quiet_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        !pready |-> (prdata == '0));

    // R6
    en_follow_chk: assert property (@(posedge pclk) disable iff (!preset_n)
        (xfer_done && pwrite && sel_ctrl && !slv_rst) |=> (periph_en == $past(pwdata[0])));

endmodule

// File: tb/apb_ctrl_regbank_tb.sv
`timescale 1ns/1ps
module apb_ctrl_regbank_tb_top;

    localparam int AW   = 10;
    localparam int DW   = 32;
    localparam int WAIT = 2;
    localparam int NSCR = 2;

    logic          pclk;
    logic          preset_n;
    logic          slv_rst;
    logic          psel;
    logic          penable;
    logic          pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata;
    logic [DW-1:0] prdata;
    logic          pready;
    logic          periph_en;

    apb_ctrl_regbank #(
        .ADDR_W(AW), .DATA_W(DW), .WAIT_CYCLES(WAIT), .NUM_SCRATCH(NSCR)
    ) dut_i (
        .pclk(pclk), .preset_n(preset_n), .slv_rst(slv_rst), .psel(psel),
        .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .periph_en(periph_en)
    );

    initial pclk = 1'b0;
    always #2.5 pclk = ~pclk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done_f = 1'b0;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl;
    logic [31:0] m_scr [NSCR];
    int          m_acc;

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        if (a == 0) return m_ctrl;
        if (a == 4) return {30'b0, (WAIT > 0), m_ctrl[0]};
        for (int k = 0; k < NSCR; k++)
            if (int'(a) == 8 + 4 * k) return m_scr[k];
        return 32'h0;
    endfunction

    function automatic string tag_for(input logic [AW-1:0] a);
        if (a == 0) return "R5";
        if (a == 4) return "R7";
        for (int k = 0; k < NSCR; k++)
            if (int'(a) == 8 + 4 * k) return "R8";
        return "R9";
    endfunction

    always @(posedge pclk or negedge preset_n) begin
        if (!preset_n) begin
            m_ctrl = 0;
            for (int k = 0; k < NSCR; k++) m_scr[k] = 0;
            m_acc = 0;
        end else if (slv_rst) begin
            m_ctrl = 0;
            for (int k = 0; k < NSCR; k++) m_scr[k] = 0;
            m_acc = 0;
        end else if (!psel) begin
            m_acc = 0;
        end else if (penable) begin
            if (m_acc == WAIT) begin
                if (pwrite) begin
                    if (paddr == 0) m_ctrl = pwdata;
                    for (int k = 0; k < NSCR; k++)
                        if (int'(paddr) == 8 + 4 * k) m_scr[k] = pwdata;
                end
                m_acc = 0;
            end else begin
                m_acc = m_acc + 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge pclk) begin
        if (preset_n && !done_f) begin
            logic        e_rdy;
            logic [31:0] e_rd;
            e_rdy = psel && penable && (m_acc == WAIT);
            e_rd  = (e_rdy && !pwrite) ? m_read(paddr) : 32'h0;
            chk(pready === e_rdy, "R3", {31'b0, pready}, {31'b0, e_rdy});
            chk(prdata === e_rd, e_rdy ? tag_for(paddr) : "R10", prdata, e_rd);
            chk(periph_en === m_ctrl[0], "R6", {31'b0, periph_en}, {31'b0, m_ctrl[0]});
        end
    end

    // watchdog
    always @(posedge pclk) begin
        cyc++;
        if (cyc > 20000 && !done_f) begin
            done_f = 1'b1;
            n_bad++;
            $display("FAIL R3: watchdog actual %0d cycles expected below 20000", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- bus tasks ----------------
    task automatic apb_xfer(input logic w, input logic [AW-1:0] a,
                            input logic [31:0] d, output logic [31:0] q);
        int   waits;
        logic old_en;
        waits  = 0;
        q      = 32'h0;
        old_en = periph_en;
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        forever begin
            @(negedge pclk);
            if (pready) begin
                q = prdata;
                break;
            end
            // R10: no data before completion
            chk(prdata == 0, "R10", prdata, 32'h0);
            // R4: control not updated during wait cycles
            if (w && a == 0)
                chk(periph_en == old_en, "R4", {31'b0, periph_en}, {31'b0, old_en});
            waits++;
            if (waits > 50) break;
        end
        chk(waits == WAIT, "R3", waits, WAIT);
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] q;
        apb_xfer(1'b1, a, d, q);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] q;
        apb_xfer(1'b0, a, 32'h0, q);
        chk(q == exp, req, q, exp);
    endtask

    task automatic apb_abort(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge pclk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(posedge pclk); #1;
        penable = 1'b1;
        @(posedge pclk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    // ---------------- stimulus ----------------
    initial begin
        preset_n = 1'b0; slv_rst = 1'b0;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
        #12;
        // R1: outputs cleared under system reset
        chk(pready == 1'b0, "R1", {31'b0, pready}, 32'h0);
        chk(prdata == 0, "R1", prdata, 32'h0);
        chk(periph_en == 1'b0, "R1", {31'b0, periph_en}, 32'h0);
        @(posedge pclk); #1;
        preset_n = 1'b1;

        rd_chk(10'h000, 32'h0, "R1");
        wr(10'h000, 32'hA5A5_0001);
        #1;
        chk(periph_en == 1'b1, "R6", {31'b0, periph_en}, 32'h1);
        rd_chk(10'h000, 32'hA5A5_0001, "R5");

        // status register
        rd_chk(10'h004, 32'h0000_0003, "R7");
        wr(10'h004, 32'hFFFF_FFFC);
        rd_chk(10'h004, 32'h0000_0003, "R7");
        rd_chk(10'h000, 32'hA5A5_0001, "R7");

        // scratch words
        wr(10'h008, 32'h1234_5678);
        wr(10'h00C, 32'hDEAD_BEEF);
        rd_chk(10'h008, 32'h1234_5678, "R8");
        rd_chk(10'h00C, 32'hDEAD_BEEF, "R8");

        // unmapped and misaligned addresses
        wr(10'h3FC, 32'hFFFF_FFFF);
        wr(10'h00A, 32'h5555_5555);
        wr(10'h010, 32'h7777_7777);
        rd_chk(10'h3FC, 32'h0, "R9");
        rd_chk(10'h00A, 32'h0, "R9");
        rd_chk(10'h010, 32'h0, "R9");
        rd_chk(10'h000, 32'hA5A5_0001, "R9");
        rd_chk(10'h008, 32'h1234_5678, "R9");
        rd_chk(10'h00C, 32'hDEAD_BEEF, "R9");

        // R4: write 0 to control, old enable must hold through the wait cycles
        wr(10'h000, 32'h0000_0000);
        #1;
        chk(periph_en == 1'b0, "R4", {31'b0, periph_en}, 32'h0);
        rd_chk(10'h004, 32'h0000_0002, "R7");

        // R11: dropped transfer
        apb_abort(10'h000, 32'hFFFF_FFFF);
        apb_abort(10'h008, 32'h0BAD_0BAD);
        rd_chk(10'h000, 32'h0, "R11");
        rd_chk(10'h008, 32'h1234_5678, "R11");

        // R2: local slave reset
        wr(10'h000, 32'h0000_0101);
        @(posedge pclk); #1;
        slv_rst = 1'b1;
        @(posedge pclk); #1;
        slv_rst = 1'b0;
        chk(periph_en == 1'b0, "R2", {31'b0, periph_en}, 32'h0);
        rd_chk(10'h000, 32'h0, "R2");
        rd_chk(10'h008, 32'h0, "R2");
        rd_chk(10'h00C, 32'h0, "R2");

        // R1: asynchronous system reset between edges
        wr(10'h000, 32'h0000_0001);
        wr(10'h00C, 32'hCAFE_F00D);
        @(posedge pclk); #1;
        preset_n = 1'b0;
        #0.5;
        chk(periph_en == 1'b0, "R1", {31'b0, periph_en}, 32'h0);
        chk(pready == 1'b0, "R1", {31'b0, pready}, 32'h0);
        @(posedge pclk); #1;
        preset_n = 1'b1;
        rd_chk(10'h000, 32'h0, "R1");
        rd_chk(10'h00C, 32'h0, "R1");

        repeat (3) @(posedge pclk);
        done_f = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule